// File: doc/BRIEF.md
# D-Channel Echo and Access Controller

This block sits beside a group of basic-rate line channels and handles access to the shared D channel. On the subscriber side it builds the echo bit returned to terminals on every channel. A 2-bit mode value sets the rule for that bit. It can copy the received D bit. It can form a wired-AND across a selectable group of channels, so the group behaves as one logical passive bus. It can also pass the received bit straight or inverted under a per-channel command code. On the terminal side it drives a ready/stop line with its own output enable toward a local HDLC controller.

Every echo bit is registered and changes only when the D-timeslot strobe is high. A side-select input chooses the subscriber role (0) or the terminal role (1). The mode value also sets the sense of the ready line and whether it changes in step with the timeslots.

The ready line is driven by a three-state machine: `RS_OFF`, `RS_STOP` and `RS_GO`.
- Leaving terminal control (side 0 or mode 0x) sends any state to `RS_OFF`.
- Returning to terminal control moves `RS_OFF` to `RS_STOP`.
- `RS_STOP` moves to `RS_GO` on an advance cycle with the release input high.
- `RS_GO` moves to `RS_STOP` on an advance cycle where the transmitted D bit differs from the received echo bit.
- In mode 10 an advance cycle is a strobe cycle. In mode 11 every clock is an advance cycle.

Top module: `dch_echo_ctrl`

## Requirements
- R1: A synchronous reset (rst_n low at a clock edge) sets every echo bit to 1 and puts the ready line in the stop state: 0 in mode 10, 1 in mode 11.
- R2: Echo bits keep their value on every clock edge where slot_i is low.
- R3: On the subscriber side (side_i=0) in mode 00 or mode 01, a strobe loads each echo bit with its own channel's received D bit. rdy_oe_o is 0 in modes 00 and 01.
- R4: On the subscriber side in mode 10, a strobe loads echo bit i with the AND of rx_d_i[i] and rx_d_i[j] for every j where sel_mask_i[j] is 1.
- R5: On the subscriber side in mode 11, a strobe loads echo bit i with the inverse of rx_d_i[i] when that channel's command code (cmd_i[4i+3:4i]) is 4'b1100. It loads rx_d_i[i] unchanged when the code is 4'b1000.
- R6: On the subscriber side in mode 11, a strobe loads echo bit i with 1 when its command code is any value other than 4'b1100 or 4'b1000.
- R7: With side_i=1, a strobe loads every echo bit with 1. rdy_oe_o is 1 exactly when side_i=1 and mode_i is 10 or 11.
- R8: On the terminal side in mode 10, rdy_o is 1 for go and 0 for stop and changes only on the edge after a strobe. A strobe cycle with tx_d_i different from echo_rx_i, while in go, gives stop.
- R9: On the terminal side in mode 10, a strobe cycle with release_i high, while in stop, gives go.
- R10: On the terminal side in mode 11, rdy_o is 0 for go and 1 for stop. Transitions happen on any clock edge with no strobe needed: a tx_d_i/echo_rx_i mismatch stops, and release_i high while stopped goes.
- R11: After any cycle outside terminal control (side_i=0 or mode 0x), the ready line starts in stop when terminal control resumes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| mode_i | input | 2 | Mode: 00 transparent, 01 treated as 00, 10 synchronous/passive bus, 11 arbiter/asynchronous |
| side_i | input | 1 | 0 subscriber role (echo generation), 1 terminal role (ready generation) |
| slot_i | input | 1 | D-timeslot strobe |
| rx_d_i | input | NCH | Received D bit of each channel |
| sel_mask_i | input | NCH | Channels joined to the passive-bus AND |
| cmd_i | input | 4*NCH | Per-channel command code, channel i at bits 4i+3:4i |
| tx_d_i | input | 1 | D bit sent by the local HDLC controller (terminal side) |
| echo_rx_i | input | 1 | Echo bit received from the line (terminal side) |
| release_i | input | 1 | HDLC controller releases transmission |
| echo_o | output | NCH | Registered echo bit of each channel |
| rdy_o | output | 1 | Ready/stop line, sense set by mode |
| rdy_oe_o | output | 1 | Output enable of the ready line |

## Verification
A wrong echo lane stays hidden until the next strobe, and a wrong lane sets a single channel to the wrong value. After that strobe the fault shows on echo_o one clock later and stays there until the following strobe. A wrong ready-machine state, such as a missed collision, a lost release, or leaving `RS_OFF` into go instead of stop, shows on rdy_o. It appears on the clock after the advance cycle that should have moved the machine, and it persists until a later advance cycle corrects it. That makes rdy_o a good place to catch it. A reset fault shows as a 0 echo bit or a go level on the first cycle after reset.

// File: rtl/dch_pkg.sv
package dch_pkg;

    localparam int CMD_W = 4;

    typedef enum logic [1:0] {
        MODE_TRANSP = 2'b00,
        MODE_RSVD   = 2'b01,
        MODE_SYNC   = 2'b10,
        MODE_ARB    = 2'b11
    } dmode_e;

    typedef enum logic [1:0] {
        RS_OFF  = 2'b00,
        RS_STOP = 2'b01,
        RS_GO   = 2'b10
    } rstate_e;

    localparam logic [CMD_W-1:0] CMD_INVERT = 4'b1100;
    localparam logic [CMD_W-1:0] CMD_PASS   = 4'b1000;

endpackage

// File: rtl/dch_echo_lane.sv
module dch_echo_lane
    import dch_pkg::*;
#(
    parameter int NCH = 4,
    parameter int IDX = 0
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             slot_i,
    input  logic             side_i,
    input  logic [1:0]       mode_i,
    input  logic [NCH-1:0]   rx_all_i,
    input  logic [NCH-1:0]   mask_i,
    input  logic [CMD_W-1:0] cmd_i,
    output logic             echo_o
);

    logic bus_and;
    logic echo_nxt;
    logic echo_q;

    // wired-AND over own channel plus every selected channel
    always_comb begin
        bus_and = 1'b1;
        for (int j = 0; j < NCH; j++) begin
            if (mask_i[j] || (j == IDX)) begin
                bus_and = bus_and & rx_all_i[j];
            end
        end
    end

    always_comb begin
        echo_nxt = 1'b1;
        if (!side_i) begin
            unique case (dmode_e'(mode_i))
                MODE_TRANSP, MODE_RSVD: echo_nxt = rx_all_i[IDX];
                MODE_SYNC:              echo_nxt = bus_and;
                MODE_ARB: begin
                    if (cmd_i == CMD_INVERT)    echo_nxt = ~rx_all_i[IDX];
                    else if (cmd_i == CMD_PASS) echo_nxt = rx_all_i[IDX];
                    else                        echo_nxt = 1'b1;
                end
                default:                echo_nxt = 1'b1;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            echo_q <= 1'b1;
        end else if (slot_i) begin
            echo_q <= echo_nxt;
        end
    end

    assign echo_o = echo_q;

endmodule

// File: rtl/dch_rdy_fsm.sv
module dch_rdy_fsm
    import dch_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       slot_i,
    input  logic       side_i,
    input  logic [1:0] mode_i,
    input  logic       tx_d_i,
    input  logic       echo_rx_i,
    input  logic       release_i,
    output logic       rdy_o,
    output logic       rdy_oe_o
);

    rstate_e state_q;
    rstate_e state_nxt;
    logic    active;
    logic    advance;
    logic    collide;

    assign active  = side_i & mode_i[1];
    assign advance = (dmode_e'(mode_i) == MODE_ARB) ? 1'b1 : slot_i;
    assign collide = tx_d_i ^ echo_rx_i;

    // next state
    always_comb begin
        state_nxt = state_q;
        if (!active) begin
            state_nxt = RS_OFF;
        end else begin
            unique case (state_q)
                RS_OFF:  state_nxt = RS_STOP;
                RS_STOP: if (advance && release_i) state_nxt = RS_GO;
                RS_GO:   if (advance && collide)   state_nxt = RS_STOP;
                default: state_nxt = RS_STOP;
            endcase
        end
    end

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= RS_STOP;
        else        state_q <= state_nxt;
    end

    // outputs
    always_comb begin
        rdy_oe_o = active;
        unique case (state_q)
            RS_GO:   rdy_o = (dmode_e'(mode_i) == MODE_ARB) ? 1'b0 : 1'b1;
            default: rdy_o = (dmode_e'(mode_i) == MODE_ARB) ? 1'b1 : 1'b0;
        endcase
    end

endmodule

// File: rtl/dch_echo_ctrl.sv
module dch_echo_ctrl
    import dch_pkg::*;
#(
    parameter int NCH = 4
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [1:0]         mode_i,
    input  logic               side_i,
    input  logic               slot_i,
    input  logic [NCH-1:0]     rx_d_i,
    input  logic [NCH-1:0]     sel_mask_i,
    input  logic [NCH*4-1:0]   cmd_i,
    input  logic               tx_d_i,
    input  logic               echo_rx_i,
    input  logic               release_i,
    output logic [NCH-1:0]     echo_o,
    output logic               rdy_o,
    output logic               rdy_oe_o
);

    for (genvar g = 0; g < NCH; g++) begin : g_lane
        dch_echo_lane #(
            .NCH (NCH),
            .IDX (g)
        ) u_lane (
            .clk      (clk),
            .rst_n    (rst_n),
            .slot_i   (slot_i),
            .side_i   (side_i),
            .mode_i   (mode_i),
            .rx_all_i (rx_d_i),
            .mask_i   (sel_mask_i),
            .cmd_i    (cmd_i[g*CMD_W +: CMD_W]),
            .echo_o   (echo_o[g])
        );
    end

    dch_rdy_fsm u_rdy (
        .clk       (clk),
        .rst_n     (rst_n),
        .slot_i    (slot_i),
        .side_i    (side_i),
        .mode_i    (mode_i),
        .tx_d_i    (tx_d_i),
        .echo_rx_i (echo_rx_i),
        .release_i (release_i),
        .rdy_o     (rdy_o),
        .rdy_oe_o  (rdy_oe_o)
    );

endmodule

// File: rtl/dch_echo_ctrl_chk.sv
module dch_echo_ctrl_chk #(
    parameter int NCH = 4
) (
    input logic               clk,
    input logic               rst_n,
    input logic [1:0]         mode_i,
    input logic               side_i,
    input logic               slot_i,
    input logic [NCH-1:0]     rx_d_i,
    input logic [NCH*4-1:0]   cmd_i,
    input logic               tx_d_i,
    input logic               echo_rx_i,
    input logic               release_i,
    input logic [NCH-1:0]     echo_o,
    input logic               rdy_o,
    input logic               rdy_oe_o
);

    logic live;

    always_ff @(posedge clk) begin
        if (!rst_n) live <= 1'b0;
        else        live <= 1'b1;
    end

    // R2
    echo_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (live && !$past(slot_i)) |-> $stable(echo_o));

    // R3
    transp_copy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (live && $past(slot_i && !side_i && !mode_i[1])) |-> (echo_o == $past(rx_d_i)));

    // R5
    arb_invert_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (live && $past(slot_i && !side_i && (mode_i == 2'b11) && (cmd_i[3:0] == 4'b1100)))
        |-> (echo_o[0] == !$past(rx_d_i[0])));

    // R7
    term_idle_echo_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (live && $past(slot_i && side_i)) |-> (&echo_o));

    // R8
    sync_rdy_steady_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (live && $past(rdy_oe_o && (mode_i == 2'b10) && !slot_i) && rdy_oe_o && (mode_i == 2'b10))
        |-> $stable(rdy_o));

    // R10
    async_stop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (live && $past(rdy_oe_o && (mode_i == 2'b11) && (tx_d_i != echo_rx_i) && !release_i)
         && rdy_oe_o && (mode_i == 2'b11)) |-> rdy_o);

endmodule

bind dch_echo_ctrl dch_echo_ctrl_chk #(.NCH(NCH)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .mode_i    (mode_i),
    .side_i    (side_i),
    .slot_i    (slot_i),
    .rx_d_i    (rx_d_i),
    .cmd_i     (cmd_i),
    .tx_d_i    (tx_d_i),
    .echo_rx_i (echo_rx_i),
    .release_i (release_i),
    .echo_o    (echo_o),
    .rdy_o     (rdy_o),
    .rdy_oe_o  (rdy_oe_o)
);

// File: tb/test_dch_echo_ctrl.sv
module test_dch_echo_ctrl;

    localparam int NCH    = 4;
    localparam int CLK_NS = 10;

    localparam int ST_OFF  = 0;
    localparam int ST_STOP = 1;
    localparam int ST_GO   = 2;

    logic               clk = 1'b0;
    logic               rst_n;
    logic [1:0]         mode_i;
    logic               side_i;
    logic               slot_i;
    logic [NCH-1:0]     rx_d_i;
    logic [NCH-1:0]     sel_mask_i;
    logic [NCH*4-1:0]   cmd_i;
    logic               tx_d_i;
    logic               echo_rx_i;
    logic               release_i;
    logic [NCH-1:0]     echo_o;
    logic               rdy_o;
    logic               rdy_oe_o;

    int checks   = 0;
    int failures = 0;
    bit done     = 1'b0;

    logic [NCH-1:0] exp_echo;
    string          exp_tag [NCH];
    int             exp_st;
    string          rtag;

    always #(CLK_NS/2) clk = ~clk;

    dch_echo_ctrl #(.NCH(NCH)) i_dch_echo_ctrl (
        .clk        (clk),
        .rst_n      (rst_n),
        .mode_i     (mode_i),
        .side_i     (side_i),
        .slot_i     (slot_i),
        .rx_d_i     (rx_d_i),
        .sel_mask_i (sel_mask_i),
        .cmd_i      (cmd_i),
        .tx_d_i     (tx_d_i),
        .echo_rx_i  (echo_rx_i),
        .release_i  (release_i),
        .echo_o     (echo_o),
        .rdy_o      (rdy_o),
        .rdy_oe_o   (rdy_oe_o)
    );

    function automatic logic bus_and(int idx, logic [NCH-1:0] rx, logic [NCH-1:0] m);
        logic v = 1'b1;
        for (int j = 0; j < NCH; j++) if (m[j] || j == idx) v = v & rx[j];
        return v;
    endfunction

    function automatic logic rdy_level(logic [1:0] md, int st);
        if (md == 2'b11) return (st == ST_GO) ? 1'b0 : 1'b1;
        return (st == ST_GO) ? 1'b1 : 1'b0;
    endfunction

    task automatic check1(string req, string what, logic act, logic exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s %s actual=%b expected=%b", req, what, act, exp);
        end
    endtask

    // advance model with current inputs, clock once, compare at negedge
    task automatic step();
        logic active, adv;
        logic [3:0] c;
        if (!rst_n) begin
            exp_echo = '1;
            for (int i = 0; i < NCH; i++) exp_tag[i] = "R1";
            exp_st = ST_STOP;
            rtag   = "R1";
        end else begin
            for (int i = 0; i < NCH; i++) begin
                if (!slot_i) exp_tag[i] = "R2";
                else if (side_i) begin
                    exp_echo[i] = 1'b1; exp_tag[i] = "R7";
                end else if (!mode_i[1]) begin
                    exp_echo[i] = rx_d_i[i]; exp_tag[i] = "R3";
                end else if (mode_i == 2'b10) begin
                    exp_echo[i] = bus_and(i, rx_d_i, sel_mask_i); exp_tag[i] = "R4";
                end else begin
                    c = cmd_i[4*i +: 4];
                    if (c == 4'b1100)      begin exp_echo[i] = ~rx_d_i[i]; exp_tag[i] = "R5"; end
                    else if (c == 4'b1000) begin exp_echo[i] = rx_d_i[i];  exp_tag[i] = "R5"; end
                    else                   begin exp_echo[i] = 1'b1;       exp_tag[i] = "R6"; end
                end
            end
            active = side_i & mode_i[1];
            adv    = (mode_i == 2'b11) ? 1'b1 : slot_i;
            rtag   = (mode_i == 2'b11) ? "R10" : "R8";
            if (!active) exp_st = ST_OFF;
            else if (exp_st == ST_OFF) begin exp_st = ST_STOP; rtag = "R11"; end
            else if (exp_st == ST_STOP) begin
                if (adv && release_i) begin
                    exp_st = ST_GO;
                    if (mode_i == 2'b10) rtag = "R9";
                end
            end else if (adv && (tx_d_i != echo_rx_i)) exp_st = ST_STOP;
        end
        @(negedge clk);
        for (int i = 0; i < NCH; i++) check1(exp_tag[i], $sformatf("echo_o[%0d]", i), echo_o[i], exp_echo[i]);
        check1(side_i ? "R7" : "R3", "rdy_oe_o", rdy_oe_o, side_i & mode_i[1]);
        if (side_i & mode_i[1]) check1(rtag, "rdy_o", rdy_o, rdy_level(mode_i, exp_st));
    endtask

    task automatic rand_cmd();
        for (int i = 0; i < NCH; i++) begin
            case ($urandom % 3)
                0:       cmd_i[4*i +: 4] = 4'b1100;
                1:       cmd_i[4*i +: 4] = 4'b1000;
                default: cmd_i[4*i +: 4] = 4'($urandom);
            endcase
        end
    endtask

    task automatic rand_term(logic [1:0] md, int n);
        side_i = 1'b1; mode_i = md;
        for (int k = 0; k < n; k++) begin
            slot_i    = ($urandom % 4) == 0;
            tx_d_i    = 1'($urandom);
            echo_rx_i = (($urandom % 5) == 0) ? ~tx_d_i : tx_d_i;
            release_i = ($urandom % 6) == 0;
            rx_d_i    = NCH'($urandom);
            step();
        end
    endtask

    initial begin
        void'($urandom(32'd20240611));
        rst_n = 1'b0; mode_i = 2'b11; side_i = 1'b1; slot_i = 1'b1;
        rx_d_i = '0; sel_mask_i = '0; cmd_i = '0;
        tx_d_i = 1'b0; echo_rx_i = 1'b0; release_i = 1'b0;
        @(negedge clk);
        step();                               // R1 stop level in mode 11
        mode_i = 2'b10; step();               // R1 stop level in mode 10
        rst_n = 1'b1;

        // directed: passive bus with one low selected channel (R4)
        side_i = 1'b0; mode_i = 2'b10; slot_i = 1'b1;
        rx_d_i = 4'b1101; sel_mask_i = 4'b0011; step();
        // directed: arbiter codes (R5, R6)
        mode_i = 2'b11; rx_d_i = 4'b0101; cmd_i = {4'b0000, 4'b1000, 4'b1100, 4'b1100};
        step();
        // directed: reserved mode behaves as transparent (R3)
        mode_i = 2'b01; rx_d_i = 4'b0110; step();
        // directed: hold without strobe (R2)
        slot_i = 1'b0; rx_d_i = 4'b1001; step(); step();

        // directed terminal mode 10: release then collision (R9, R8, R11)
        side_i = 1'b1; mode_i = 2'b10; slot_i = 1'b0; release_i = 1'b1; step();
        slot_i = 1'b1; step();
        release_i = 1'b0; slot_i = 1'b0; tx_d_i = 1'b0; echo_rx_i = 1'b1; step();
        slot_i = 1'b1; step();
        // directed terminal mode 11: asynchronous go and stop (R10)
        mode_i = 2'b11; slot_i = 1'b0; release_i = 1'b1; step();
        release_i = 1'b0; step();
        tx_d_i = 1'b1; step();

        // random subscriber side
        side_i = 1'b0;
        for (int k = 0; k < 1500; k++) begin
            mode_i = 2'($urandom); slot_i = ($urandom % 3) == 0;
            rx_d_i = NCH'($urandom); sel_mask_i = NCH'($urandom);
            rand_cmd();
            step();
        end
        rand_term(2'b10, 1500);
        rand_term(2'b11, 1500);
        // fully mixed, including role and mode changes (R11)
        for (int k = 0; k < 2000; k++) begin
            side_i = 1'($urandom); mode_i = 2'($urandom);
            slot_i = ($urandom % 3) == 0; rx_d_i = NCH'($urandom);
            sel_mask_i = NCH'($urandom); rand_cmd();
            tx_d_i = 1'($urandom); echo_rx_i = (($urandom % 4) == 0) ? ~tx_d_i : tx_d_i;
            release_i = ($urandom % 5) == 0;
            rst_n = ($urandom % 200) != 0;
            step();
        end
        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            failures++;
            $display("FAIL watchdog expired");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

endmodule